// File: doc/BRIEF.md
# Scan-Chain Debug Register Access

This block is a test-access-port data register that lets a debug host read and write a small bank of internal debug registers over the serial scan path. Each scan moves a 38-bit frame. The frame holds a 32-bit data word, a 5-bit register address and a direction flag. Frames are shifted least significant bit first, from `tdi` toward `tdo`.

Nothing happens to the register bank while bits are being shifted. The frame is acted on only on the clock edge where the update strobe is high:

- A write frame stores its data word into the addressed register.
- A read frame only records the address.

On the next capture, the recorded register's value is loaded into the data field of the shift register. The following scan then carries that value out on `tdo`. A read therefore costs two scans.

The TAP controller sits outside this block and supplies one-cycle capture, shift and update strobes, all synchronous to `tck`. The current contents of the bank are also presented on a flat output, so that the debug logic that consumes them can use them.

Top module: `dbg_scan_access`

## Requirements
- R1: On a `tck` rising edge with `shift_dr` high and `capture_dr` low, the frame moves one place toward bit 0. `tdi` enters bit 37, and `tdo` always shows bit 0. Data occupies bits 31:0, the address occupies bits 36:32, and the direction flag sits in bit 37.
- R2: An edge with `update_dr` high and flag bit 37 = 1 writes bits 31:0 into register `bits 36:32`. The new value is visible on `dbg_regs[32*k +: 32]` after that edge.
- R3: An update with flag bit 37 = 0 leaves every register unchanged, whatever the data field holds. It records bits 36:32 as the read address.
- R4: Shifting never changes any register; the bank changes only on an update edge.
- R5: On an edge with `capture_dr` high, the frame is loaded with the following fields:
  - bits 31:0: the register at the recorded read address;
  - bits 36:32: the recorded read address;
  - bit 37: 0.
- R6: A write to an address at or above `NUM_REGS` (default 12) changes no register. A read of such an address captures zero data.
- R7: With no strobe high, the shift register and `tdo` hold their value.
- R8: While `rst_n` is low, and for two `tck` edges after it rises, the following hold:
  - all registers read zero;
  - the read address is 0;
  - the shift register is zero, so `tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on `tck` |
| capture_dr | input | 1 | TAP strobe: load frame from selected register |
| shift_dr | input | 1 | TAP strobe: shift one bit |
| update_dr | input | 1 | TAP strobe: act on the shifted frame |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (frame bit 0) |
| dbg_regs | output | NUM_REGS*32 | Contents of the debug register bank, register k at bits 32k+31:32k |

## Verification
The bench drives the following corner cases:
- **Read with a non-zero data field.** A design that wrote on every update would corrupt the addressed register.
- **Mid-shift inspection of the bank.** A design that decoded the frame while shifting would change registers before the update edge.
- **Out-of-range addresses in both directions.** A design that indexed the bank without bounding the address would write to an aliased register, or return stale data instead of zero.
- **Idle gap between capture and shift.** A design that shifted outside the shift strobe would lose the captured bits.

A scoreboard compares every scanned-out frame, so a wrong bit order or a wrong field placement shows up as a frame mismatch.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 5;
  localparam int FRAME_W  = DATA_W + ADDR_W + 1;
  localparam int ADDR_LSB = DATA_W;
  localparam int RW_BIT   = DATA_W + ADDR_W;
endpackage

// File: rtl/dbg_scan_shreg.sv
module dbg_scan_shreg
  import dbg_scan_pkg::*;
(
  input  logic              tck,
  input  logic              rst_ni,
  input  logic              capture,
  input  logic              shift,
  input  logic              tdi,
  input  logic [DATA_W-1:0] cap_data,
  input  logic [ADDR_W-1:0] cap_addr,
  output logic [FRAME_W-1:0] frame,
  output logic              tdo
);
  logic [FRAME_W-1:0] sr_q, sr_nxt;
  logic               sr_en;

  always_comb begin
    sr_en  = capture | shift;
    sr_nxt = sr_q;
    if (capture)    sr_nxt = {1'b0, cap_addr, cap_data};
    else if (shift) sr_nxt = {tdi, sr_q[FRAME_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_ni) begin
    if (!rst_ni)    sr_q <= '0;
    else if (sr_en) sr_q <= sr_nxt;
  end

  assign frame = sr_q;
  assign tdo   = sr_q[0];

  assert_shift_in_R1: assert property (@(posedge tck) disable iff (!rst_ni)
    (shift && !capture) |=> (sr_q[FRAME_W-1] == $past(tdi)) &&
                            (sr_q[FRAME_W-2:0] == $past(sr_q[FRAME_W-1:1])));

  assert_capture_R5: assert property (@(posedge tck) disable iff (!rst_ni)
    capture |=> (sr_q[DATA_W-1:0] == $past(cap_data)) && !sr_q[RW_BIT] &&
                (sr_q[RW_BIT-1:ADDR_LSB] == $past(cap_addr)));

  assert_hold_R7: assert property (@(posedge tck) disable iff (!rst_ni)
    (!capture && !shift) |=> $stable(sr_q));
endmodule

// File: rtl/dbg_scan_decode.sv
module dbg_scan_decode
  import dbg_scan_pkg::*;
(
  input  logic               tck,
  input  logic               rst_ni,
  input  logic               update,
  input  logic [FRAME_W-1:0] frame,
  output logic               wr_en,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0]  wr_data,
  output logic [ADDR_W-1:0]  rd_addr
);
  logic              rd_load;
  logic [ADDR_W-1:0] rd_addr_q, rd_addr_nxt;

  always_comb begin
    wr_en       = update & frame[RW_BIT];
    wr_addr     = frame[RW_BIT-1:ADDR_LSB];
    wr_data     = frame[DATA_W-1:0];
    rd_load     = update & ~frame[RW_BIT];
    rd_addr_nxt = rd_load ? frame[RW_BIT-1:ADDR_LSB] : rd_addr_q;
  end

  always_ff @(posedge tck or negedge rst_ni) begin
    if (!rst_ni)      rd_addr_q <= '0;
    else if (rd_load) rd_addr_q <= rd_addr_nxt;
  end

  assign rd_addr = rd_addr_q;

  assert_rd_addr_idle_R3: assert property (@(posedge tck) disable iff (!rst_ni)
    !update |=> $stable(rd_addr_q));

  assert_rd_addr_on_write_R2: assert property (@(posedge tck) disable iff (!rst_ni)
    (update && frame[RW_BIT]) |=> $stable(rd_addr_q));
endmodule

// File: rtl/dbg_reg_bank.sv
module dbg_reg_bank
  import dbg_scan_pkg::*;
#(
  parameter int NUM_REGS = 12
) (
  input  logic                       tck,
  input  logic                       rst_ni,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  logic [DATA_W-1:0]   q [NUM_REGS];
  logic [NUM_REGS-1:0] hit;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    assign hit[g] = wr_en && (int'(wr_addr) == g);
    assign regs_flat[g*DATA_W +: DATA_W] = q[g];

    assert_write_R2: assert property (@(posedge tck) disable iff (!rst_ni)
      (wr_en && int'(wr_addr) == g) |=> (q[g] == $past(wr_data)));
  end

  always_ff @(posedge tck or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) if (hit[i]) q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (int'(rd_addr) == i) rd_data = q[i];
  end

  assert_unimpl_write_R6: assert property (@(posedge tck) disable iff (!rst_ni)
    (wr_en && int'(wr_addr) >= NUM_REGS) |=> $stable(regs_flat));

  assert_unimpl_read_R6: assert property (@(posedge tck) disable iff (!rst_ni)
    (int'(rd_addr) >= NUM_REGS) |-> (rd_data == '0));
endmodule

// File: rtl/dbg_scan_access.sv
module dbg_scan_access
  import dbg_scan_pkg::*;
#(
  parameter int NUM_REGS = 12
) (
  input  logic                       tck,
  input  logic                       rst_n,
  input  logic                       capture_dr,
  input  logic                       shift_dr,
  input  logic                       update_dr,
  input  logic                       tdi,
  output logic                       tdo,
  output logic [NUM_REGS*DATA_W-1:0] dbg_regs
);
  logic [1:0]         rst_sync_q;
  logic               rst_i_n;
  logic [FRAME_W-1:0] frame;
  logic               wr_en;
  logic [ADDR_W-1:0]  wr_addr, rd_addr;
  logic [DATA_W-1:0]  wr_data, rd_data;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  dbg_scan_shreg u_shreg (
    .tck      (tck),
    .rst_ni   (rst_i_n),
    .capture  (capture_dr),
    .shift    (shift_dr),
    .tdi      (tdi),
    .cap_data (rd_data),
    .cap_addr (rd_addr),
    .frame    (frame),
    .tdo      (tdo)
  );

  dbg_scan_decode u_decode (
    .tck     (tck),
    .rst_ni  (rst_i_n),
    .update  (update_dr),
    .frame   (frame),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr)
  );

  dbg_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .tck       (tck),
    .rst_ni    (rst_i_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .regs_flat (dbg_regs)
  );

  assert_no_access_in_shift_R4: assert property (@(posedge tck) disable iff (!rst_i_n)
    (!update_dr) |=> $stable(dbg_regs));

  assert_read_keeps_bank_R3: assert property (@(posedge tck) disable iff (!rst_i_n)
    (update_dr && !frame[RW_BIT]) |=> $stable(dbg_regs));

  assert_reset_state_R8: assert property (@(posedge tck)
    !rst_i_n |-> (dbg_regs == '0) && (rd_addr == '0) && !tdo);
endmodule

// File: tb/dbg_scan_access_tb.sv
`timescale 1ns/1ps
module dbg_scan_access_tb;
  localparam int NR = 12;

  logic tck = 1'b0;
  logic rst_n, capture_dr, shift_dr, update_dr, tdi, tdo;
  logic [NR*32-1:0] dbg_regs;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [31:0] mreg [NR];
  int          mrd;
  logic [37:0] exp_q [$];
  logic [37:0] obs;
  event        obs_ev;

  always #4 tck = ~tck;

  dbg_scan_access #(.NUM_REGS(NR)) u_dut (
    .tck(tck), .rst_n(rst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .tdi(tdi), .tdo(tdo), .dbg_regs(dbg_regs)
  );

  task automatic check(string tag, logic [NR*32-1:0] act, logic [NR*32-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NR*32-1:0] model_flat();
    logic [NR*32-1:0] f;
    for (int i = 0; i < NR; i++) f[i*32 +: 32] = mreg[i];
    return f;
  endfunction

  function automatic logic [37:0] model_cap();
    logic [31:0] d;
    d = (mrd < NR) ? mreg[mrd] : 32'h0;
    return {1'b0, 5'(mrd), d};
  endfunction

  // Scoreboard monitor: compares each scanned-out frame with the expected capture (R5, R1)
  initial begin
    forever begin
      @(obs_ev);
      if (exp_q.size() == 0) check("R5 unexpected frame", NR*32'(obs), '0);
      else begin
        logic [37:0] e;
        e = exp_q.pop_front();
        check("R5 R1 scanned frame", NR*32'(obs), NR*32'(e));
      end
    end
  end

  task automatic scan(bit rw, logic [4:0] a, logic [31:0] d, int gap);
    logic [37:0] fr;
    logic [37:0] e;
    e = model_cap();
    exp_q.push_back(e);
    fr = {rw, a, d};
    @(negedge tck); capture_dr = 1'b1;
    @(negedge tck); capture_dr = 1'b0;
    for (int g = 0; g < gap; g++) begin
      check("R7 tdo holds while idle", NR*32'(tdo), NR*32'(e[0]));
      @(negedge tck);
    end
    for (int i = 0; i < 38; i++) begin
      obs[i] = tdo;
      tdi = fr[i];
      shift_dr = 1'b1;
      if (i == 20) check("R4 bank unchanged mid-shift", dbg_regs, model_flat());
      @(negedge tck);
    end
    shift_dr = 1'b0;
    check("R4 bank unchanged before update", dbg_regs, model_flat());
    update_dr = 1'b1;
    @(negedge tck); update_dr = 1'b0;
    ->obs_ev;
    if (rw) begin
      if (int'(a) < NR) mreg[a] = d;
    end else mrd = int'(a);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge tck);
    for (int i = 0; i < NR; i++) mreg[i] = '0;
    mrd = 0;
    check("R8 bank zero in reset", dbg_regs, '0);
    check("R8 tdo zero in reset", NR*32'(tdo), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge tck);
  endtask

  initial begin
    capture_dr = 0; shift_dr = 0; update_dr = 0; tdi = 0;
    do_reset();

    scan(1'b1, 5'd3, 32'hA5A5_1234, 0);
    check("R2 write reg3", dbg_regs, model_flat());
    scan(1'b1, 5'd0, 32'hDEAD_BEEF, 0);
    scan(1'b1, 5'd11, 32'h8000_0001, 0);
    check("R2 write reg0 and reg11", dbg_regs, model_flat());

    scan(1'b0, 5'd3, 32'hFFFF_FFFF, 0);
    check("R3 read leaves bank unchanged", dbg_regs, model_flat());
    scan(1'b0, 5'd11, 32'h1357_9BDF, 2);
    scan(1'b1, 5'd20, 32'h0BAD_0BAD, 3);
    check("R6 unimplemented write discarded", dbg_regs, model_flat());
    scan(1'b0, 5'd31, 32'h0, 0);
    scan(1'b1, 5'd5, 32'h0000_00C3, 1);
    scan(1'b0, 5'd5, 32'h0, 0);
    scan(1'b0, 5'd0, 32'h0, 0);

    repeat (5) begin
      @(negedge tck);
      check("R7 tdo stable with no strobe", NR*32'(tdo), '0);
    end

    do_reset();
    scan(1'b1, 5'd0, 32'h7777_0000, 0);
    scan(1'b1, 5'd1, 32'h0000_0001, 0);
    scan(1'b0, 5'd1, 32'h0, 0);
    check("R8 bank after second reset", dbg_regs, model_flat());

    repeat (3) @(negedge tck);
    check("R5 scoreboard drained", NR*32'(exp_q.size()), '0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule